// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is a serial slave that lets an outside controller read and write a bank of sixteen 16-bit control registers over three pins: an active-low frame enable, a serial clock and a single data line shared by both directions. The data line is modelled as an input, an output and an active-low output enable, so the pad that combines them stays outside the block. All register state sits in the serial clock domain. The whole bank is exported as one flat vector so the rest of the chip can use the control values directly.

A frame opens at the first rising clock edge that sees the enable low. Nine control bits follow on rising edges. They carry a four-bit chip identity, a direction flag placed inside the identity field, and a four-bit register index. A write frame then delivers sixteen data bits, most significant first. A read frame leaves half a cycle for the controller to let go of the line, and the slave then shifts sixteen register bits out, one per rising edge, for the controller to sample on falling edges. Frames that carry a foreign chip identity, or that end early, leave both the bank and the line untouched. Each pin carries plain data with no handshake, so there is no back-pressure. The controller sets the pace entirely through the clock and the enable.

Top module: `three_wire_slave`

## Requirements
- R1: Control bits are sampled on consecutive rising edges starting at the first edge with `sen_n` low. Their order on the wire is chip[3], chip[2], chip[1], direction, chip[0], index[3], index[2], index[1], index[0].
- R2: A frame whose chip field is not 4'b0110 changes no register and never drives the line (`sdio_oe_n` stays 1).
- R3: With direction 0 (write), the next 16 rising edges supply data MSB first. Register k takes the word only at the edge of the 16th data bit, and appears at `regs_flat[16k+15:16k]`.
- R4: With direction 1 (read), `sdio_oe_n` stays high through the edge that samples index[0]. From the following rising edge on, bit 15 down to bit 0 of the register are launched, one per rising edge, and the line is released at the next rising edge.
- R5: If `sen_n` rises before the 16th write bit, no register changes.
- R6: `sdio_oe_n` is 1 whenever `sen_n` is 1, with no clock edge needed.
- R7: After `rst_n` low, all registers read 0 and the line is undriven.
- R8: A rising edge with `sen_n` high closes the frame. A new frame may begin at the very next edge, and the clock may run freely between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sen_n | input | 1 | Active-low frame enable |
| sdio_in | input | 1 | Value seen on the shared data line |
| sdio_out | output | 1 | Value the slave places on the line while driving |
| sdio_oe_n | output | 1 | Active-low drive enable for the data line |
| regs_flat | output | 256 | All sixteen registers, register k in bits [16k+15:16k] |

## Verification
The bench builds the block with its default parameters: 16-bit words, a four-bit index and a chip identity of 4'b0110. With these settings every index from 0 to 15 can be reached, including both ends of the bank. Foreign identities come from random choice, so identities that differ from 4'b0110 in only one bit are covered alongside the directed ones. Aborts are placed at random bit positions inside both the control word and the data phase, and back-to-back frames with no idle clock show that the closing edge is enough to separate two frames.

// File: rtl/twr_pkg.sv
package twr_pkg;
  localparam int CTRL_BITS = 9;
  localparam int IDX_BITS  = 4;

  typedef struct packed {
    logic [3:0]          chip;
    logic                rd;
    logic [IDX_BITS-1:0] idx;
  } ctrl_t;

  // wire order: chip[3] chip[2] chip[1] dir chip[0] idx[3..0]
  function automatic ctrl_t unpack_ctrl(input logic [CTRL_BITS-1:0] w);
    ctrl_t c;
    c.chip = {w[8:6], w[4]};
    c.rd   = w[5];
    c.idx  = w[3:0];
    return c;
  endfunction
endpackage

// File: rtl/twr_frame_seq.sv
module twr_frame_seq
  import twr_pkg::*;
#(
  parameter int          DW      = 16,
  parameter logic [3:0]  CHIP_ID = 4'b0110,
  localparam int         LAST    = CTRL_BITS + DW,
  localparam int         CW      = $clog2(LAST + 1)
) (
  input  logic                sclk,
  input  logic                rst_n,
  input  logic                sen_n,
  input  logic                sdi,
  output logic [CW-1:0]       cnt,
  output logic                hit,
  output logic                rd,
  output logic [IDX_BITS-1:0] idx
);
  localparam logic [CW-1:0] CNT_LAST  = CW'(LAST);
  localparam logic [CW-1:0] CNT_CTRLZ = CW'(CTRL_BITS - 1);

  logic [CTRL_BITS-2:0] sh_q;
  logic [CW-1:0]        cnt_q;
  logic                 hit_q;
  ctrl_t                ctrl_q;
  ctrl_t                ctrl_d;

  assign ctrl_d = unpack_ctrl({sh_q, sdi});

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      hit_q  <= 1'b0;
      ctrl_q <= '0;
    end else if (sen_n) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else begin
      if (cnt_q != CNT_LAST) cnt_q <= cnt_q + 1'b1;
      if (cnt_q < CNT_CTRLZ) sh_q <= {sh_q[CTRL_BITS-3:0], sdi};
      if (cnt_q == CNT_CTRLZ) begin
        ctrl_q <= ctrl_d;
        hit_q  <= (ctrl_d.chip == CHIP_ID);
      end
    end
  end

  assign cnt = cnt_q;
  assign hit = hit_q;
  assign rd  = ctrl_q.rd;
  assign idx = ctrl_q.idx;
endmodule

// File: rtl/twr_wr_path.sv
module twr_wr_path
  import twr_pkg::*;
#(
  parameter int  DW   = 16,
  localparam int LAST = CTRL_BITS + DW,
  localparam int CW   = $clog2(LAST + 1)
) (
  input  logic          sclk,
  input  logic          rst_n,
  input  logic          sen_n,
  input  logic          sdi,
  input  logic [CW-1:0] cnt,
  input  logic          hit,
  input  logic          rd,
  output logic          we,
  output logic [DW-1:0] wdata
);
  localparam logic [CW-1:0] CNT_D0   = CW'(CTRL_BITS);
  localparam logic [CW-1:0] CNT_DEND = CW'(LAST - 1);

  logic [DW-2:0] sh_q;
  logic          in_data;

  assign in_data = !sen_n && hit && !rd && (cnt >= CNT_D0) && (cnt <= CNT_DEND);

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)       sh_q <= '0;
    else if (in_data) sh_q <= {sh_q[DW-3:0], sdi};
  end

  // commit on the edge that samples the last data bit
  assign we    = in_data && (cnt == CNT_DEND);
  assign wdata = {sh_q, sdi};
endmodule

// File: rtl/twr_reg_bank.sv
module twr_reg_bank #(
  parameter int  DW   = 16,
  parameter int  AW   = 4,
  localparam int NREG = 2 ** AW
) (
  input  logic               sclk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  output logic [NREG*DW-1:0] flat
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n)                        q <= '0;
      else if (we && addr == AW'(g))     q <= wdata;
    end
    assign flat[g*DW +: DW] = q;
  end

  assign rdata = flat[addr*DW +: DW];
endmodule

// File: rtl/twr_rd_path.sv
module twr_rd_path
  import twr_pkg::*;
#(
  parameter int  DW   = 16,
  localparam int LAST = CTRL_BITS + DW,
  localparam int CW   = $clog2(LAST + 1)
) (
  input  logic          sclk,
  input  logic          rst_n,
  input  logic          sen_n,
  input  logic [CW-1:0] cnt,
  input  logic          hit,
  input  logic          rd,
  input  logic [DW-1:0] rdata,
  output logic          sdo,
  output logic          oe_n
);
  localparam logic [CW-1:0] CNT_D0   = CW'(CTRL_BITS);
  localparam logic [CW-1:0] CNT_DEND = CW'(LAST - 1);

  logic [DW-1:0] sh_q;
  logic          drv_q;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      drv_q <= 1'b0;
    end else if (sen_n) begin
      drv_q <= 1'b0;
    end else if (hit && rd && cnt == CNT_D0) begin
      sh_q  <= rdata;
      drv_q <= 1'b1;
    end else if (drv_q && cnt <= CNT_DEND) begin
      sh_q <= {sh_q[DW-2:0], 1'b0};
    end else begin
      drv_q <= 1'b0;
    end
  end

  assign sdo  = sh_q[DW-1];
  assign oe_n = !(drv_q && !sen_n);
endmodule

// File: rtl/three_wire_slave.sv
module three_wire_slave
  import twr_pkg::*;
#(
  parameter int         DW      = 16,
  parameter logic [3:0] CHIP_ID = 4'b0110,
  localparam int        NREG    = 2 ** IDX_BITS,
  localparam int        CW      = $clog2(CTRL_BITS + DW + 1)
) (
  input  logic               sclk,
  input  logic               rst_n,
  input  logic               sen_n,
  input  logic               sdio_in,
  output logic               sdio_out,
  output logic               sdio_oe_n,
  output logic [NREG*DW-1:0] regs_flat
);
  logic [CW-1:0]       cnt;
  logic                hit, rd, we;
  logic [IDX_BITS-1:0] idx;
  logic [DW-1:0]       wdata, rdata;

  twr_frame_seq #(.DW(DW), .CHIP_ID(CHIP_ID)) u_seq (
    .sclk(sclk), .rst_n(rst_n), .sen_n(sen_n), .sdi(sdio_in),
    .cnt(cnt), .hit(hit), .rd(rd), .idx(idx)
  );

  twr_wr_path #(.DW(DW)) u_wr (
    .sclk(sclk), .rst_n(rst_n), .sen_n(sen_n), .sdi(sdio_in),
    .cnt(cnt), .hit(hit), .rd(rd), .we(we), .wdata(wdata)
  );

  twr_reg_bank #(.DW(DW), .AW(IDX_BITS)) u_bank (
    .sclk(sclk), .rst_n(rst_n), .we(we), .addr(idx),
    .wdata(wdata), .rdata(rdata), .flat(regs_flat)
  );

  twr_rd_path #(.DW(DW)) u_rd (
    .sclk(sclk), .rst_n(rst_n), .sen_n(sen_n), .cnt(cnt),
    .hit(hit), .rd(rd), .rdata(rdata), .sdo(sdio_out), .oe_n(sdio_oe_n)
  );
endmodule

// File: rtl/twr_chk.sv
module twr_chk #(
  parameter int         DW      = 16,
  parameter logic [3:0] CHIP_ID = 4'b0110,
  parameter int         NREG    = 16
) (
  input logic               sclk,
  input logic               rst_n,
  input logic               sen_n,
  input logic               sdio_in,
  input logic               sdio_oe_n,
  input logic [NREG*DW-1:0] regs_flat
);
  localparam int LAST = 9 + DW;

  int         ck_cnt;
  logic [7:0] ck_sh;
  logic       ck_hit, ck_miss, ck_rd;
  logic       ck_wr_edge;

  assign ck_wr_edge = !sen_n && ck_hit && !ck_rd && (ck_cnt == LAST - 1);

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      ck_cnt <= 0; ck_sh <= '0; ck_hit <= 1'b0; ck_miss <= 1'b0; ck_rd <= 1'b0;
    end else if (sen_n) begin
      ck_cnt <= 0; ck_hit <= 1'b0; ck_miss <= 1'b0;
    end else begin
      if (ck_cnt < LAST) ck_cnt <= ck_cnt + 1;
      if (ck_cnt < 8) ck_sh <= {ck_sh[6:0], sdio_in};
      if (ck_cnt == 8) begin
        ck_hit  <= ({ck_sh[7:5], ck_sh[3]} == CHIP_ID);
        ck_miss <= ({ck_sh[7:5], ck_sh[3]} != CHIP_ID);
        ck_rd   <= ck_sh[4];
      end
    end
  end

  AST_RELEASE_WHEN_IDLE: assert property (@(posedge sclk) disable iff (!rst_n)
    sen_n |-> sdio_oe_n);                                            // R6
  AST_QUIET_DURING_CTRL: assert property (@(posedge sclk) disable iff (!rst_n)
    (ck_cnt <= 9) |-> sdio_oe_n);                                    // R4
  AST_FOREIGN_CHIP_QUIET: assert property (@(posedge sclk) disable iff (!rst_n)
    ck_miss |-> sdio_oe_n);                                          // R2
  AST_BANK_CHANGES_ON_COMMIT: assert property (@(posedge sclk) disable iff (!rst_n)
    !$stable(regs_flat) |-> $past(ck_wr_edge));                      // R3
endmodule

bind three_wire_slave twr_chk #(.DW(DW), .CHIP_ID(CHIP_ID), .NREG(NREG)) u_chk (
  .sclk(sclk), .rst_n(rst_n), .sen_n(sen_n), .sdio_in(sdio_in),
  .sdio_oe_n(sdio_oe_n), .regs_flat(regs_flat)
);

// File: tb/sim_three_wire_slave.sv
module sim_three_wire_slave;
  localparam int PERIOD = 10;
  localparam int DW     = 16;
  localparam int NREG   = 16;
  localparam int FULL   = 9 + DW;
  localparam logic [3:0] ID = 4'b0110;

  logic sclk = 1'b0, rst_n = 1'b0, sen_n = 1'b1, sdio_in = 1'b0;
  logic sdio_out, sdio_oe_n;
  logic [NREG*DW-1:0] regs_flat;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] model [NREG];

  three_wire_slave u0 (
    .sclk(sclk), .rst_n(rst_n), .sen_n(sen_n), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe_n(sdio_oe_n), .regs_flat(regs_flat)
  );

  always #(PERIOD/2) sclk = ~sclk;

  function automatic logic [8:0] pack_ctrl(input logic [3:0] chip, input logic rd,
                                           input logic [3:0] idx);
    return {chip[3:1], rd, chip[0], idx};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_bank(input string req);
    int bad = -1;
    for (int k = 0; k < NREG; k++)
      if (regs_flat[k*DW +: DW] !== model[k] && bad < 0) bad = k;
    if (bad < 0) check(1'b1, req, 0, 0);
    else check(1'b0, req, {16'(bad), regs_flat[bad*DW +: DW]}, {16'(bad), model[bad]});
  endtask

  task automatic frame(input logic [3:0] chip, input logic rd, input logic [3:0] idx,
                       input logic [DW-1:0] wdata, input int nbits);
    logic [8:0]    cw;
    logic [DW-1:0] rdata;
    bit            hit;
    int            bad_drive;
    cw = pack_ctrl(chip, rd, idx);
    rdata = '0;
    hit = (chip == ID);
    bad_drive = 0;
    for (int i = 0; i <= nbits; i++) begin
      @(negedge sclk);
      if (i >= 1) begin
        int j = i - 1;
        bit exp_drive = hit && rd && j >= 9 && j <= FULL - 1;
        if ((sdio_oe_n == 1'b0) != exp_drive) bad_drive++;
        if (exp_drive) rdata[FULL-1-j] = sdio_out;
      end
      if (i < nbits) begin
        sen_n = 1'b0;
        if (i < 9) sdio_in = cw[8-i];
        else sdio_in = rd ? 1'($urandom % 2) : wdata[FULL-1-i];
      end else begin
        sen_n = 1'b1;
      end
    end
    #1;
    check(sdio_oe_n == 1'b1, "R6", 32'(sdio_oe_n), 32'd1);
    check(bad_drive == 0, !hit ? "R2" : (rd ? "R4" : "R3"), bad_drive, 0);
    if (hit && !rd && nbits == FULL) model[idx] = wdata;
    if (hit && rd && nbits == FULL) check(rdata == model[idx], "R4", rdata, model[idx]);
    if (!hit) check_bank("R2");
    else if (nbits < FULL) check_bank("R5");
    else check_bank("R3");
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0301));
    for (int k = 0; k < NREG; k++) model[k] = '0;
    repeat (3) @(negedge sclk);
    rst_n = 1'b1;
    @(negedge sclk);
    check(regs_flat == '0, "R7", 32'(regs_flat[31:0]), 32'd0);
    check(sdio_oe_n == 1'b1, "R7", 32'(sdio_oe_n), 32'd1);

    // bank ends and readback
    frame(ID, 1'b0, 4'd0,  16'hA5C3, FULL);
    frame(ID, 1'b0, 4'd15, 16'h8001, FULL);
    frame(ID, 1'b1, 4'd0,  16'h0000, FULL);
    frame(ID, 1'b1, 4'd15, 16'h0000, FULL);

    // R1: index bit order and field placement
    frame(ID, 1'b0, 4'd1, 16'h1111, FULL);
    frame(ID, 1'b0, 4'd8, 16'h8888, FULL);
    check(regs_flat[1*DW +: DW] == 16'h1111 && regs_flat[8*DW +: DW] == 16'h8888, "R1",
          {regs_flat[1*DW +: DW], regs_flat[8*DW +: DW]}, 32'h1111_8888);

    // R2: foreign identities
    frame(4'b0111, 1'b0, 4'd3, 16'hDEAD, FULL);
    frame(4'b1110, 1'b1, 4'd0, 16'h0000, FULL);
    frame(4'b0100, 1'b0, 4'd0, 16'hBEEF, FULL);

    // R5: aborted write one bit short, aborted read in mid data
    frame(ID, 1'b0, 4'd2, 16'hFFFF, FULL - 1);
    frame(ID, 1'b1, 4'd0, 16'h0000, 15);
    frame(ID, 1'b0, 4'd0, 16'h1234, 5);

    // R8: back-to-back frames, no idle edge
    frame(ID, 1'b0, 4'd5, 16'h5555, FULL);
    frame(ID, 1'b0, 4'd6, 16'h6666, FULL);
    frame(ID, 1'b1, 4'd5, 16'h0000, FULL);
    check(regs_flat[5*DW +: DW] == 16'h5555 && regs_flat[6*DW +: DW] == 16'h6666, "R8",
          {regs_flat[5*DW +: DW], regs_flat[6*DW +: DW]}, 32'h5555_6666);

    for (int n = 0; n < 300; n++) begin
      logic [3:0] chip = ($urandom % 4 == 0) ? 4'($urandom) : ID;
      int nb = ($urandom % 5 == 0) ? 1 + int'($urandom % (FULL - 1)) : FULL;
      frame(chip, 1'($urandom), 4'($urandom), 16'($urandom), nb);
      repeat ($urandom % 4) @(negedge sclk);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule